// File: doc/BRIEF.md
# PHY Discovery and Link Resolver

This block brings an Ethernet port from "unknown PHY" to "MAC configured" without software. On a start pulse it walks the management address space looking for the first PHY that answers. It reads that PHY's identifier word to pick a decode family. It then polls the PHY's basic status word until the link comes up or a retry budget runs out. Last, it reads the family's own status register to learn the negotiated speed and duplex.

All register traffic goes through a simple request/response port toward an existing MDIO management master. The block never touches the serial management wires itself. A request is a PHY address plus a register number, held until the master accepts it. Only one request is ever outstanding, and each one is answered by a single response beat carrying 16 bits of data.

The results stay on the output ports until the next start. They are the PHY address, a family code, link-ok, a 2-bit speed code and a 2-bit duplex code. The block also derives three MAC configuration bits from the speed and duplex codes. The retry budget and the idle gap between link polls are parameters, given in attempts and clock cycles.

Top module: `phy_link_sense`

## Requirements
- R1: After start, presence reads of register 1 go to PHY addresses 1, 2, 3, … in ascending order, never to address 0 or above 31, and scanning stops at the first populated address.
- R2: An address is populated when its register-1 value is anything other than 0x0000 or 0xFFFF.
- R3: If none of addresses 1 to 31 is populated, the outputs at the end of the run are `notFound`=1, `linkOk`=0, `phyAddr`=0, `phyFamily`=0, and speed and duplex codes of 0.
- R4: Register 2 of the found PHY sets `phyFamily`. The mapping is 0x0016→1, 0x0022→2, 0x0141→3, 0x0302→4, 0x0013→5, and any other value→6.
- R5: Link polling reads register 1 of the found PHY and looks at bit 2. It makes at most LINK_TRIES reads, with at least POLL_DELAY idle cycles between consecutive reads. If no read shows bit 2 set, `linkOk` stays 0 and no vendor status register is read.
- R6: Family 1 reads register 18. Bit 7 set gives 100 Mb/s and clear gives 10 Mb/s. Bit 6 set gives full duplex.
- R7: Families 2 and 4 read register 18. Bit 10 set gives 100 Mb/s and clear gives 10 Mb/s. Bit 11 set gives full duplex.
- R8: Family 3 reads register 17. Bits 15:14 = 2 give 1000 Mb/s, = 1 give 100 Mb/s, and any other value gives 10 Mb/s. Bit 13 set gives full duplex.
- R9: Family 5 reads register 17. Bits 15:14 = 3 give 1000 Mb/s, = 2 give 100 Mb/s, and any other value gives 10 Mb/s. Bit 9 set gives full duplex.
- R10: `speedCode` is 1 for 10, 2 for 100 and 3 for 1000 Mb/s. `duplexCode` is 1 for half and 2 for full duplex. `macSel10` is set only for 10 Mb/s, `macSel1000` only for 1000 Mb/s, and `macFullDuplex` only for full duplex, so 100 Mb/s sets neither speed select.
- R11: Family 6 with link up reads no vendor status register and leaves the speed and duplex codes and the MAC bits at 0.
- R12: A request stays valid with a stable address and register until accepted. `done` is a one-cycle pulse. `start` clears all result outputs, and `start` while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin discovery (ignored while busy) |
| mdioReqValid | output | 1 | Read request valid toward the management master |
| mdioReqReady | input | 1 | Master accepts the request |
| mdioReqPhy | output | 5 | PHY address of the request |
| mdioReqReg | output | 5 | Register number of the request |
| mdioRspValid | input | 1 | Read data beat valid |
| mdioRspData | input | 16 | Read data |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| notFound | output | 1 | No PHY answered at addresses 1 to 31 |
| phyAddr | output | 5 | Address of the found PHY |
| phyFamily | output | 3 | Family code (R4) |
| linkOk | output | 1 | Link seen up |
| speedCode | output | 2 | 0 unknown, 1/2/3 = 10/100/1000 Mb/s |
| duplexCode | output | 2 | 0 unknown, 1 half, 2 full |
| macSel10 | output | 1 | MAC 10 Mb/s select |
| macSel1000 | output | 1 | MAC 1000 Mb/s select |
| macFullDuplex | output | 1 | MAC full-duplex select |

## Verification
The bound checker watches, on every cycle, the invariants that hold at the ports:
- request stability under backpressure and a nonzero request address;
- `done` lasting a single cycle;
- quiet link outputs when no PHY was found;
- exclusive MAC speed selects;
- nonzero codes after a resolved link of a known family, and zero codes for the unknown family.

The bench scenarios are needed for the rest:
- the scan order and stopping point;
- the identifier-to-family table;
- each family's bit decode;
- the number of link reads and the gap between them;
- the absence of a vendor read when the link never comes up;
- ignoring a start pulse while busy.

// File: rtl/phy_sense_pkg.sv
package phy_sense_pkg;

  typedef enum logic [2:0] {
    FAM_NONE   = 3'd0,
    FAM_ID16   = 3'd1,
    FAM_ID22   = 3'd2,
    FAM_ID141  = 3'd3,
    FAM_ID302  = 3'd4,
    FAM_ID13   = 3'd5,
    FAM_OTHER  = 3'd6
  } famT;

  typedef enum logic [1:0] {
    SEL_PRESENCE = 2'd0,
    SEL_IDENT    = 2'd1,
    SEL_VENDOR   = 2'd2
  } regSelT;

  // strobes from control to datapath
  typedef struct packed {
    logic   clrAll;
    logic   addrInc;
    logic   latchPhy;
    logic   latchFam;
    logic   triesInc;
    logic   delayLoad;
    logic   delayTick;
    logic   setLink;
    logic   latchStat;
    logic   setNotFound;
    regSelT regSel;
  } stbT;

  function automatic famT classifyId(input logic [15:0] id);
    case (id)
      16'h0016: return FAM_ID16;
      16'h0022: return FAM_ID22;
      16'h0141: return FAM_ID141;
      16'h0302: return FAM_ID302;
      16'h0013: return FAM_ID13;
      default:  return FAM_OTHER;
    endcase
  endfunction

  function automatic logic [4:0] vendorReg(input famT fam);
    case (fam)
      FAM_ID16, FAM_ID22, FAM_ID302: return 5'd18;
      FAM_ID141, FAM_ID13:           return 5'd17;
      default:                       return 5'd0;
    endcase
  endfunction

  // returns {speedCode, duplexCode}
  function automatic logic [3:0] decodeStat(input famT fam, input logic [15:0] d);
    logic [1:0] spd;
    logic [1:0] dpx;
    spd = 2'd0;
    dpx = 2'd0;
    case (fam)
      FAM_ID16: begin
        spd = d[7] ? 2'd2 : 2'd1;
        dpx = d[6] ? 2'd2 : 2'd1;
      end
      FAM_ID22, FAM_ID302: begin
        spd = d[10] ? 2'd2 : 2'd1;
        dpx = d[11] ? 2'd2 : 2'd1;
      end
      FAM_ID141: begin
        spd = (d[15:14] == 2'd2) ? 2'd3 : (d[15:14] == 2'd1) ? 2'd2 : 2'd1;
        dpx = d[13] ? 2'd2 : 2'd1;
      end
      FAM_ID13: begin
        spd = (d[15:14] == 2'd3) ? 2'd3 : (d[15:14] == 2'd2) ? 2'd2 : 2'd1;
        dpx = d[9] ? 2'd2 : 2'd1;
      end
      default: begin
        spd = 2'd0;
        dpx = 2'd0;
      end
    endcase
    return {spd, dpx};
  endfunction

endpackage

// File: rtl/phy_sense_ctrl.sv
module phy_sense_ctrl
  import phy_sense_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic reqReady,
  input  logic rspValid,
  input  logic populated,
  input  logic addrLast,
  input  logic linkBit,
  input  logic triesLast,
  input  logic pauseDone,
  input  logic famOther,
  output stbT  stb,
  output logic reqValid,
  output logic busy,
  output logic done
);

  typedef enum logic [3:0] {
    S_IDLE, S_SCAN_REQ, S_SCAN_RSP, S_ID_REQ, S_ID_RSP,
    S_LINK_REQ, S_LINK_RSP, S_PAUSE, S_STAT_REQ, S_STAT_RSP, S_DONE
  } stateT;

  stateT state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    stb      = '0;
    nxt      = state;
    reqValid = 1'b0;
    done     = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          stb.clrAll = 1'b1;
          nxt        = S_SCAN_REQ;
        end
      end
      S_SCAN_REQ: begin
        reqValid   = 1'b1;
        stb.regSel = SEL_PRESENCE;
        if (reqReady) nxt = S_SCAN_RSP;
      end
      S_SCAN_RSP: begin
        stb.regSel = SEL_PRESENCE;
        if (rspValid) begin
          if (populated) begin
            stb.latchPhy = 1'b1;
            nxt          = S_ID_REQ;
          end else if (addrLast) begin
            stb.setNotFound = 1'b1;
            nxt             = S_DONE;
          end else begin
            stb.addrInc = 1'b1;
            nxt         = S_SCAN_REQ;
          end
        end
      end
      S_ID_REQ: begin
        reqValid   = 1'b1;
        stb.regSel = SEL_IDENT;
        if (reqReady) nxt = S_ID_RSP;
      end
      S_ID_RSP: begin
        stb.regSel = SEL_IDENT;
        if (rspValid) begin
          stb.latchFam = 1'b1;
          nxt          = S_LINK_REQ;
        end
      end
      S_LINK_REQ: begin
        reqValid   = 1'b1;
        stb.regSel = SEL_PRESENCE;
        if (reqReady) nxt = S_LINK_RSP;
      end
      S_LINK_RSP: begin
        stb.regSel = SEL_PRESENCE;
        if (rspValid) begin
          if (linkBit) begin
            stb.setLink = 1'b1;
            nxt         = famOther ? S_DONE : S_STAT_REQ;
          end else if (triesLast) begin
            nxt = S_DONE;
          end else begin
            stb.triesInc  = 1'b1;
            stb.delayLoad = 1'b1;
            nxt           = S_PAUSE;
          end
        end
      end
      S_PAUSE: begin
        stb.delayTick = 1'b1;
        if (pauseDone) nxt = S_LINK_REQ;
      end
      S_STAT_REQ: begin
        reqValid   = 1'b1;
        stb.regSel = SEL_VENDOR;
        if (reqReady) nxt = S_STAT_RSP;
      end
      S_STAT_RSP: begin
        stb.regSel = SEL_VENDOR;
        if (rspValid) begin
          stb.latchStat = 1'b1;
          nxt           = S_DONE;
        end
      end
      S_DONE: begin
        done = 1'b1;
        nxt  = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/phy_sense_dp.sv
module phy_sense_dp
  import phy_sense_pkg::*;
#(
  parameter int LINK_TRIES = 4096,
  parameter int POLL_DELAY = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  stbT         stb,
  input  logic [15:0] rspData,
  output logic [4:0]  reqPhy,
  output logic [4:0]  reqReg,
  output logic        populated,
  output logic        addrLast,
  output logic        linkBit,
  output logic        triesLast,
  output logic        pauseDone,
  output logic        famOther,
  output logic [4:0]  phyAddr,
  output logic [2:0]  family,
  output logic        linkOk,
  output logic        notFound,
  output logic [1:0]  speedCode,
  output logic [1:0]  duplexCode
);

  localparam int TRIES_W = $clog2(LINK_TRIES + 1);
  localparam int DLY_W   = $clog2(POLL_DELAY + 1);
  localparam logic [4:0] LAST_ADDR = 5'd31;

  logic [4:0]       addr;
  logic [4:0]       phyAddrQ;
  famT              famQ;
  logic             linkQ;
  logic             nfQ;
  logic [1:0]       speedQ;
  logic [1:0]       dupQ;
  logic [TRIES_W-1:0] tries;
  logic [DLY_W-1:0]   dly;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr     <= 5'd1;
      phyAddrQ <= '0;
      famQ     <= FAM_NONE;
      linkQ    <= 1'b0;
      nfQ      <= 1'b0;
      speedQ   <= '0;
      dupQ     <= '0;
      tries    <= '0;
      dly      <= '0;
    end else begin
      if (stb.clrAll) begin
        addr     <= 5'd1;
        phyAddrQ <= '0;
        famQ     <= FAM_NONE;
        linkQ    <= 1'b0;
        nfQ      <= 1'b0;
        speedQ   <= '0;
        dupQ     <= '0;
        tries    <= '0;
      end
      if (stb.addrInc)     addr     <= addr + 5'd1;
      if (stb.latchPhy)    phyAddrQ <= addr;
      if (stb.latchFam)    famQ     <= classifyId(rspData);
      if (stb.triesInc)    tries    <= tries + 1'b1;
      if (stb.setLink)     linkQ    <= 1'b1;
      if (stb.setNotFound) nfQ      <= 1'b1;
      if (stb.latchStat)   {speedQ, dupQ} <= decodeStat(famQ, rspData);
      if (stb.delayLoad)
        dly <= DLY_W'(POLL_DELAY - 1);
      else if (stb.delayTick && dly != '0)
        dly <= dly - 1'b1;
    end
  end

  always_comb begin
    case (stb.regSel)
      SEL_IDENT:  reqReg = 5'd2;
      SEL_VENDOR: reqReg = vendorReg(famQ);
      default:    reqReg = 5'd1;
    endcase
  end

  assign reqPhy     = addr;
  assign populated  = (rspData != 16'h0000) && (rspData != 16'hFFFF);
  assign addrLast   = (addr == LAST_ADDR);
  assign linkBit    = rspData[2];
  assign triesLast  = (tries == TRIES_W'(LINK_TRIES - 1));
  assign pauseDone  = (dly == '0);
  assign famOther   = (famQ == FAM_OTHER);
  assign phyAddr    = phyAddrQ;
  assign family     = famQ;
  assign linkOk     = linkQ;
  assign notFound   = nfQ;
  assign speedCode  = speedQ;
  assign duplexCode = dupQ;

endmodule

// File: rtl/phy_link_sense.sv
module phy_link_sense
  import phy_sense_pkg::*;
#(
  parameter int LINK_TRIES = 4096,
  parameter int POLL_DELAY = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output logic        mdioReqValid,
  input  logic        mdioReqReady,
  output logic [4:0]  mdioReqPhy,
  output logic [4:0]  mdioReqReg,
  input  logic        mdioRspValid,
  input  logic [15:0] mdioRspData,
  output logic        busy,
  output logic        done,
  output logic        notFound,
  output logic [4:0]  phyAddr,
  output logic [2:0]  phyFamily,
  output logic        linkOk,
  output logic [1:0]  speedCode,
  output logic [1:0]  duplexCode,
  output logic        macSel10,
  output logic        macSel1000,
  output logic        macFullDuplex
);

  stbT  stb;
  logic populated, addrLast, linkBit, triesLast, pauseDone, famOther;

  phy_sense_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .reqReady  (mdioReqReady),
    .rspValid  (mdioRspValid),
    .populated (populated),
    .addrLast  (addrLast),
    .linkBit   (linkBit),
    .triesLast (triesLast),
    .pauseDone (pauseDone),
    .famOther  (famOther),
    .stb       (stb),
    .reqValid  (mdioReqValid),
    .busy      (busy),
    .done      (done)
  );

  phy_sense_dp #(
    .LINK_TRIES (LINK_TRIES),
    .POLL_DELAY (POLL_DELAY)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .rspData    (mdioRspData),
    .reqPhy     (mdioReqPhy),
    .reqReg     (mdioReqReg),
    .populated  (populated),
    .addrLast   (addrLast),
    .linkBit    (linkBit),
    .triesLast  (triesLast),
    .pauseDone  (pauseDone),
    .famOther   (famOther),
    .phyAddr    (phyAddr),
    .family     (phyFamily),
    .linkOk     (linkOk),
    .notFound   (notFound),
    .speedCode  (speedCode),
    .duplexCode (duplexCode)
  );

  assign macSel10      = (speedCode == 2'd1);
  assign macSel1000    = (speedCode == 2'd3);
  assign macFullDuplex = (duplexCode == 2'd2);

endmodule

// File: rtl/phy_link_sense_chk.sv
module phy_link_sense_chk (
  input logic        clk,
  input logic        rstN,
  input logic        mdioReqValid,
  input logic        mdioReqReady,
  input logic [4:0]  mdioReqPhy,
  input logic [4:0]  mdioReqReg,
  input logic        done,
  input logic        notFound,
  input logic [2:0]  phyFamily,
  input logic        linkOk,
  input logic [1:0]  speedCode,
  input logic [1:0]  duplexCode,
  input logic        macSel10,
  input logic        macSel1000
);

  // R12: request held steady under backpressure
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    mdioReqValid && !mdioReqReady |=> mdioReqValid && $stable(mdioReqPhy) && $stable(mdioReqReg));

  // R1: never address 0
  p_addr_nonzero_r1: assert property (@(posedge clk) disable iff (!rstN)
    mdioReqValid |-> mdioReqPhy != 5'd0);

  // R12: done lasts one cycle
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3: nothing found keeps link outputs quiet
  p_notfound_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    notFound |-> !linkOk && speedCode == 2'd0 && duplexCode == 2'd0);

  // R10: known family with link gives real codes
  p_codes_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    done && linkOk && phyFamily >= 3'd1 && phyFamily <= 3'd5 |-> speedCode != 2'd0 && duplexCode != 2'd0);

  // R11: unknown family keeps defaults
  p_other_default_r11: assert property (@(posedge clk) disable iff (!rstN)
    done && phyFamily == 3'd6 |-> speedCode == 2'd0 && duplexCode == 2'd0);

  // R10: speed selects exclusive
  p_sel_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(macSel10 && macSel1000));

endmodule

bind phy_link_sense phy_link_sense_chk u_chk (.*);

// File: tb/phy_link_sense_bench.sv
module phy_link_sense_bench;

  localparam int TRIES = 6;
  localparam int GAP   = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        mdioReqValid, mdioReqReady = 1'b0;
  logic [4:0]  mdioReqPhy, mdioReqReg;
  logic        mdioRspValid = 1'b0;
  logic [15:0] mdioRspData = '0;
  logic        busy, done, notFound, linkOk;
  logic [4:0]  phyAddr;
  logic [2:0]  phyFamily;
  logic [1:0]  speedCode, duplexCode;
  logic        macSel10, macSel1000, macFullDuplex;

  phy_link_sense #(.LINK_TRIES(TRIES), .POLL_DELAY(GAP)) u_phy_link_sense (.*);

  always #10 clk = ~clk;   // 50 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nFail   = 0;

  // PHY model state
  int popAddr, linkFails, popReads;
  logic [15:0] idVal, statVal;
  // request log
  int scanNext, scanCount, linkReads, statReads, lastStatReg, lastLinkCyc, minGap;
  bit idSeen, scanErr;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] modelRead(input int phy, input int rg);
    if (phy == popAddr && popAddr != 0) begin
      if (rg == 1) begin
        popReads++;
        if (popReads == 1) return 16'h7809;
        return (popReads - 1 > linkFails) ? 16'h780D : 16'h7809;
      end
      if (rg == 2) return idVal;
      if (rg == 17 || rg == 18) return statVal;
      return 16'h0000;
    end
    if (rg == 1) return ($urandom % 2) ? 16'hFFFF : 16'h0000;
    return 16'h0000;
  endfunction

  function automatic int expFam(input logic [15:0] id);
    case (id)
      16'h0016: return 1;
      16'h0022: return 2;
      16'h0141: return 3;
      16'h0302: return 4;
      16'h0013: return 5;
      default:  return 6;
    endcase
  endfunction

  function automatic int expReg(input int fam);
    if (fam == 1 || fam == 2 || fam == 4) return 18;
    if (fam == 3 || fam == 5) return 17;
    return 0;
  endfunction

  function automatic int expSpeed(input int fam, input logic [15:0] s);
    case (fam)
      1: return s[7] ? 2 : 1;
      2, 4: return s[10] ? 2 : 1;
      3: return (s[15:14] == 2) ? 3 : (s[15:14] == 1) ? 2 : 1;
      5: return (s[15:14] == 3) ? 3 : (s[15:14] == 2) ? 2 : 1;
      default: return 0;
    endcase
  endfunction

  function automatic int expDup(input int fam, input logic [15:0] s);
    case (fam)
      1: return s[6] ? 2 : 1;
      2, 4: return s[11] ? 2 : 1;
      3: return s[13] ? 2 : 1;
      5: return s[9] ? 2 : 1;
      default: return 0;
    endcase
  endfunction

  // responder toward the block
  initial begin
    forever begin
      @(negedge clk);
      mdioRspValid = 1'b0;
      if (mdioReqValid) begin
        int phy, rg;
        repeat ($urandom % 3) @(negedge clk);
        phy = mdioReqPhy;
        rg  = mdioReqReg;
        mdioReqReady = 1'b1;
        if (rg == 1 && !idSeen) begin
          if (phy != scanNext) scanErr = 1'b1;
          scanNext++;
          scanCount++;
        end else if (rg == 1) begin
          if (linkReads > 0 && (cyc - lastLinkCyc) < minGap) minGap = cyc - lastLinkCyc;
          lastLinkCyc = cyc;
          linkReads++;
        end else if (rg == 2) begin
          idSeen = 1'b1;
        end else begin
          statReads++;
          lastStatReg = rg;
        end
        @(negedge clk);
        mdioReqReady = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
        mdioRspData  = modelRead(phy, rg);
        mdioRspValid = 1'b1;
      end
    end
  end

  task automatic runCase(input int pop, input logic [15:0] id, input logic [15:0] st,
                         input int fails, input bit restartMid);
    int t;
    int fam, expLinkReads;
    bit expLink;
    popAddr = pop; idVal = id; statVal = st; linkFails = fails; popReads = 0;
    scanNext = 1; scanCount = 0; linkReads = 0; statReads = 0; lastStatReg = 0;
    lastLinkCyc = 0; minGap = 1 << 20; idSeen = 1'b0; scanErr = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1 && linkOk == 1'b0 && speedCode == 2'd0 && notFound == 1'b0,
          "R12", "cleared and busy after start", {busy, linkOk, speedCode}, 4'b1000);
    if (restartMid) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    t = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    check(t < 20000, "R12", "run completes", t, 0);
    fam = (pop == 0) ? 0 : expFam(id);
    expLink = (pop != 0) && (fails < TRIES);
    expLinkReads = (pop == 0) ? 0 : ((fails + 1 < TRIES) ? fails + 1 : TRIES);
    @(negedge clk);
    check(!scanErr, "R1", "ascending scan order", scanErr, 0);
    check(scanCount == ((pop == 0) ? 31 : pop), "R1", "scan reads", scanCount, (pop == 0) ? 31 : pop);
    check(notFound == (pop == 0), "R3", "notFound", notFound, pop == 0);
    check(phyAddr == pop, "R2", "phyAddr", phyAddr, pop);
    check(phyFamily == fam, "R4", "family", phyFamily, fam);
    check(linkOk == expLink, "R5", "linkOk", linkOk, expLink);
    check(linkReads == expLinkReads, "R5", "link read count", linkReads, expLinkReads);
    if (linkReads > 1)
      check(minGap >= GAP, "R5", "gap between link reads", minGap, GAP);
    if (expLink && fam != 6) begin
      int es, ed;
      es = expSpeed(fam, st);
      ed = expDup(fam, st);
      check(statReads == 1 && lastStatReg == expReg(fam), "R6", "vendor register (R7 R8 R9)", lastStatReg, expReg(fam));
      check(speedCode == es, (fam == 1) ? "R6" : (fam == 3) ? "R8" : (fam == 5) ? "R9" : "R7",
            "speed", speedCode, es);
      check(duplexCode == ed, (fam == 1) ? "R6" : (fam == 3) ? "R8" : (fam == 5) ? "R9" : "R7",
            "duplex", duplexCode, ed);
      check(macSel10 == (es == 1) && macSel1000 == (es == 3) && macFullDuplex == (ed == 2),
            "R10", "MAC bits", {macSel10, macSel1000, macFullDuplex},
            {es == 1, es == 3, ed == 2});
    end else begin
      check(statReads == 0, (fam == 6) ? "R11" : "R5", "no vendor read", statReads, 0);
      check(speedCode == 0 && duplexCode == 0 && !macSel10 && !macSel1000 && !macFullDuplex,
            (fam == 6) ? "R11" : "R3", "default codes", {speedCode, duplexCode}, 0);
    end
  endtask

  initial begin
    $urandom(32'd7741);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !mdioReqValid && !linkOk && !notFound && speedCode == 0,
          "R12", "reset state", {busy, done, mdioReqValid, linkOk}, 0);
    runCase(5,  16'h0016, 16'h00C0, 2, 0);   // R6 100 full
    runCase(1,  16'h0016, 16'h0000, 0, 0);   // R6 10 half
    runCase(31, 16'h0022, 16'h0400, 1, 0);   // R7 100 half, last address
    runCase(7,  16'h0302, 16'h0800, 0, 0);   // R7 10 full
    runCase(2,  16'h0141, 16'hA000, 0, 0);   // R8 1000 full
    runCase(3,  16'h0141, 16'hC000, 0, 0);   // R8 code 3 -> 10
    runCase(4,  16'h0141, 16'h4000, 0, 0);   // R8 100
    runCase(9,  16'h0013, 16'hC200, 0, 0);   // R9 1000 full
    runCase(10, 16'h0013, 16'h8000, 3, 0);   // R9 100 half
    runCase(11, 16'h0013, 16'h4000, 0, 0);   // R9 code 1 -> 10
    runCase(6,  16'h1234, 16'hFFFF, 0, 0);   // R11 other family
    runCase(0,  16'h0016, 16'h0000, 0, 0);   // R3 nothing found
    runCase(8,  16'h0016, 16'h00C0, TRIES, 1); // R5 no link, R12 start while busy
    runCase(12, 16'h0022, 16'h0C00, TRIES - 1, 0); // R5 link on last try
    for (int i = 0; i < 8; i++) begin
      logic [15:0] ids [6];
      ids = '{16'h0016, 16'h0022, 16'h0141, 16'h0302, 16'h0013, 16'h0BAD};
      runCase(1 + ($urandom % 31), ids[$urandom % 6], 16'($urandom), $urandom % (TRIES + 1), 0);
    end
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(20 * 190000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule